// File: doc/BRIEF.md
# Pipelined Byte-Lane CRC-32 Engine

This block computes a running CRC-32 over a stream of 64-bit words. It produces, bit for bit, the same result as a single-cycle 64-bit parallel encoder. The wide XOR network that such an encoder needs is split into short stages. Each of the eight byte lanes keeps its own partial remainder. That remainder covers the lane's bytes, with each byte followed by the seven zero bytes that the other lanes occupy. A balanced tree of merge nodes then folds the lane remainders together, advancing the earlier operand by the byte span of the later one. No stage needs more than one byte-advance or one multi-byte zero-advance followed by a two-input XOR. The price is a fixed latency of six clock cycles.

A caller marks the first word of a frame with `start_i` and presents each word with `valid_i`. Every valid word yields exactly one strobe on `crc_vld_o`, carrying the remainder of all bytes since the frame began. Cycles with `valid_i` low are bubbles: they leave the running state untouched and produce no strobe. Partial final words are handled by the caller, who pads them with zero bytes. Inversion of the result is also left to the caller.

A two-state frame machine sits at the lane stage. FR_IDLE means no word has arrived since reset. FR_OPEN means a frame is in progress. The transition FR_IDLE to FR_OPEN is taken on the first valid word. Every later valid word keeps the machine in FR_OPEN. Only reset returns it to FR_IDLE. In FR_OPEN a valid word folds into the lane remainders unless it carries `start_i`, in which case the remainders restart from that word.

Top module: `pcrc_lane_tree`

## Requirements
- R1: The result is the CRC with generator 0x04C11DB7, zero initial remainder and no final inversion. Bits are taken MSB first, and byte lane 0 is `word_i[63:56]` (the earliest byte). A lone word 0x0000_0000_0000_9595 gives 0x3738F30B.
- R2: A valid word without `start_i` extends the running CRC, so the output equals the CRC of every byte since the frame began.
- R3: A valid word with `start_i` high discards earlier words; the output covers that word onward only.
- R4: A cycle with `valid_i` low changes neither the running remainder nor the strobe, and a later word continues the frame as if the bubble were absent.
- R5: The strobe `crc_vld_o` rises exactly six cycles after the edge that samples a valid word, once per valid word, and `crc_o` carries that word's result in the same cycle.
- R6: After reset, `crc_o` is zero and `crc_vld_o` is low, and the first valid word begins a new frame even without `start_i`.
- R7: Valid words on consecutive cycles are each processed with no stall, and every one yields its own correct result.
- R8: `start_i` high while `valid_i` is low has no effect; the next word without `start_i` continues the open frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 64 | Data word, earliest byte in bits 63:56 |
| valid_i | input | 1 | Word present this cycle |
| start_i | input | 1 | Word is the first of a frame (used only with valid_i) |
| crc_o | output | 32 | Running CRC after the word strobed |
| crc_vld_o | output | 1 | One-cycle strobe for each valid word |

## Verification
Each valid word has one result, and it is due on the sixth rising edge after the edge that samples the word. The driver stamps each expected remainder with the cycle count at which it must appear. The monitor samples on falling edges and compares both the value and that cycle count. A strobe that arrives with nothing pending, such as one caused by a bubble, is a failure. Expected values come from a bit-serial shift model, plus one fixed known-answer word, so no check relies on the lane-and-tree decomposition.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_OPEN = 1'b1
    } frame_e;

    // one serial step of the MSB-first shift register
    function automatic crc_t crc_shift_bit(crc_t c, logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // remainder of a single byte from a zero register
    function automatic crc_t crc_of_byte(logic [7:0] d);
        crc_t c;
        c = '0;
        for (int k = 7; k >= 0; k--) c = crc_shift_bit(c, d[k]);
        return c;
    endfunction

    // remainder after appending nbytes zero bytes
    function automatic crc_t crc_zero_adv(crc_t c, int nbytes);
        crc_t r;
        r = c;
        for (int k = 0; k < nbytes * 8; k++) r = crc_shift_bit(r, 1'b0);
        return r;
    endfunction

endpackage

// File: rtl/pcrc_lane_unit.sv
module pcrc_lane_unit
    import pcrc_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_i,
    input  logic       step_i,
    input  logic       fold_i,
    output crc_t       acc_o
);

    crc_t bc_q;
    crc_t acc_q;

    // stage A: remainder of the lone byte
    always_ff @(posedge clk) begin
        if (!rst_n) bc_q <= '0;
        else        bc_q <= crc_of_byte(byte_i);
    end

    // stage B: lane remainder, advanced by a full word of zero bytes per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step_i) begin
            if (fold_i) acc_q <= crc_zero_adv(acc_q, LANES) ^ bc_q;
            else        acc_q <= bc_q;
        end
    end

    assign acc_o = acc_q;

    assert_hold_on_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i) |=> $stable(acc_q));

endmodule

// File: rtl/pcrc_merge_node.sv
module pcrc_merge_node
    import pcrc_pkg::*;
#(
    parameter int SHIFT_BYTES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  crc_t early_i,
    input  crc_t late_i,
    output crc_t crc_o
);

    crc_t m_q;

    // earlier span is advanced past the later span, then the two are summed
    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= crc_zero_adv(early_i, SHIFT_BYTES) ^ late_i;
    end

    assign crc_o = m_q;

endmodule

// File: rtl/pcrc_lane_tree.sv
module pcrc_lane_tree
    import pcrc_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES*8-1:0]   word_i,
    input  logic                 valid_i,
    input  logic                 start_i,
    output logic [CRC_W-1:0]     crc_o,
    output logic                 crc_vld_o
);

    localparam int LOG    = $clog2(LANES);
    localparam int DATA_W = LANES * 8;
    localparam int NODES  = 2 * LANES - 1;
    localparam int LAT    = 3 + LOG;

    // stage 1: input capture
    logic [DATA_W-1:0] w1;
    logic              v1, s1;
    // stage 2: control aligned with the byte remainders
    logic              v2, s2;
    // stage 3 onward: valid pipeline through the tree
    logic              v3;
    logic [LOG-1:0]    vt;

    frame_e state_q, state_d;
    logic   fold;

    crc_t tree [NODES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w1 <= '0;
            v1 <= 1'b0;
            s1 <= 1'b0;
            v2 <= 1'b0;
            s2 <= 1'b0;
            v3 <= 1'b0;
            vt <= '0;
        end else begin
            w1 <= word_i;
            v1 <= valid_i;
            s1 <= start_i;
            v2 <= v1;
            s2 <= s1;
            v3 <= v2;
            vt <= {vt[LOG-2:0], v3};
        end
    end

    // frame state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // next state and fold decision
    always_comb begin
        state_d = state_q;
        fold    = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                if (v2) state_d = FR_OPEN;
            end
            FR_OPEN: begin
                fold = !s2;
            end
            default: state_d = FR_IDLE;
        endcase
    end

    // byte lanes: lane i is the i-th byte in time order
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pcrc_lane_unit #(.LANES(LANES)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .byte_i (w1[DATA_W-1-8*i -: 8]),
            .step_i (v2),
            .fold_i (fold),
            .acc_o  (tree[LANES-1+i])
        );
    end

    // heap-ordered merge tree: node n has children 2n+1 (earlier) and 2n+2
    for (genvar n = 0; n < LANES - 1; n++) begin : g_node
        localparam int DEPTH = $clog2(n + 2) - 1;
        localparam int HGT   = LOG - DEPTH;
        pcrc_merge_node #(.SHIFT_BYTES(1 << (HGT - 1))) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .early_i (tree[2*n+1]),
            .late_i  (tree[2*n+2]),
            .crc_o   (tree[n])
        );
    end

    assign crc_o     = tree[0];
    assign crc_vld_o = vt[LOG-1];

    // cycles since reset release, saturating (used by the checks below)
    logic [7:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 8'hFF) since_rst <= since_rst + 8'd1;
    end

    assert_strobe_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 8'(LAT)) |-> (crc_vld_o == $past(valid_i, LAT)));

    assert_quiet_after_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 8'(LAT)) |-> !crc_vld_o);

    assert_frame_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |=> (state_q == FR_OPEN));

endmodule

// File: tb/tb_pcrc_lane_tree.sv
module tb_pcrc_lane_tree;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] word_i;
    logic        valid_i;
    logic        start_i;
    logic [31:0] crc_o;
    logic        crc_vld_o;

    pcrc_lane_tree dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_i    (word_i),
        .valid_i   (valid_i),
        .start_i   (start_i),
        .crc_o     (crc_o),
        .crc_vld_o (crc_vld_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    logic [31:0] exp_q [$];
    int unsigned due_q [$];
    string       tag_q [$];

    logic [31:0] model;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] feed(input logic [31:0] c, input logic [63:0] w);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int b = 63; b >= 0; b--) begin
            fb = r[31] ^ w[b];
            r  = {r[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
        end
        return r;
    endfunction

    // drive one valid word on the current falling edge; hold it one cycle
    task automatic send(input logic [63:0] w, input bit st, input string tag);
        if (st) model = '0;
        model = feed(model, w);
        word_i  = w;
        valid_i = 1'b1;
        start_i = st;
        exp_q.push_back(model);
        due_q.push_back(cyc + LAT);
        tag_q.push_back(tag);
        @(negedge clk);
        valid_i = 1'b0;
        start_i = 1'b0;
    endtask

    task automatic bubble(input int n, input bit st);
        for (int k = 0; k < n; k++) begin
            word_i  = {$urandom, $urandom};
            valid_i = 1'b0;
            start_i = st;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic drain();
        repeat (LAT + 2) @(negedge clk);
        check(exp_q.size() == 0, "R5 results outstanding", 32'(exp_q.size()), 32'h0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && crc_vld_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R5 unexpected strobe", crc_o, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic int unsigned d = due_q.pop_front();
                automatic string       t = tag_q.pop_front();
                check(crc_o === e, t, crc_o, e);
                check(cyc == d, {"R5 timing of ", t}, 32'(cyc), 32'(d));
            end
        end
    end

    task automatic do_reset();
        rst_n   = 1'b0;
        valid_i = 1'b0;
        start_i = 1'b0;
        word_i  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = '0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check(crc_o === 32'h0, "R6 reset crc", crc_o, 32'h0);
        check(crc_vld_o === 1'b0, "R6 reset strobe", 32'(crc_vld_o), 32'h0);

        // R1 known answer, checked against the fixed constant
        send(64'h0000_0000_0000_9595, 1'b1, "R1 known answer");
        check(model === 32'h3738_F30B, "R1 model constant", model, 32'h3738_F30B);
        drain();

        // R2 / R7: back-to-back running frame
        send({$urandom, $urandom}, 1'b1, "R3 frame start");
        for (int k = 0; k < 20; k++) begin
            send({$urandom, $urandom}, 1'b0, "R7 back-to-back");
        end
        drain();

        // R4: bubbles between words
        send(64'hDEAD_BEEF_0123_4567, 1'b1, "R3 frame start");
        for (int k = 0; k < 10; k++) begin
            bubble(1 + (k % 3), 1'b0);
            send({$urandom, $urandom}, 1'b0, "R4 after bubble");
        end
        drain();

        // R3: restart in the middle of a stream
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R2 continue");
        send(64'h0102_0408_1020_4080, 1'b1, "R3 restart");
        send(64'h0, 1'b0, "R2 zero word");
        drain();

        // R8: start without valid has no effect
        bubble(2, 1'b1);
        send(64'h5555_AAAA_5555_AAAA, 1'b0, "R8 start ignored");
        send(64'h8000_0000_0000_0001, 1'b0, "R2 continue");
        drain();

        // R6: first word after a fresh reset starts a frame without start_i
        do_reset();
        @(negedge clk);
        check(crc_o === 32'h0, "R6 reset crc again", crc_o, 32'h0);
        send(64'h1234_5678_9ABC_DEF0, 1'b0, "R6 first word");
        send(64'h0F0F_F0F0_3C3C_C3C3, 1'b0, "R2 continue");
        drain();

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule